// File: doc/BRIEF.md
# Clause-22 PHY Management Master

This block is a register-programmed master for the two-wire PHY management bus. It runs clause-22 read and write transactions against registers inside external PHY devices. A host first programs a combined PHY/register address. It then launches a read by raising a command bit, or launches a write by storing the 16-bit value to send into a control-data register. The controller generates the management clock from the system clock and shifts the complete frame out on the data line. For a read, it releases the data line at the turnaround and collects the reply from the PHY.

The host sees a small word-indexed register file with a one-cycle registered read path. There is a set of indicator flags (busy, scan requested, read data not yet valid) and a status register that holds the last value read. A configuration register selects the clock divide ratio. Its top bit holds the management engine in reset while it is set.

Register indexes on `reg_addr`: 0 configuration, 1 command, 2 address, 3 control-data, 4 read status, 5 indicators.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads zero, `mdc` is low, `mdio_oe` is low, and `reg_rdata` shows the register selected by `reg_addr` one clock after it is presented.
- R2: The address register (index 2) keeps the PHY address in bits [12:8] and the register number in bits [4:0]; all other bits read back as zero.
- R3: A read starts only when a write to the command register (index 1) takes bit 0 from 0 to 1; writing 1 while bit 0 already holds 1 starts nothing.
- R4: A write to the control-data register (index 3) starts a write frame, sent MSB first: 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register number, turnaround 10, then the 16 data bits.
- R5: A read frame carries opcode 10. `mdio_oe` is low from the first turnaround bit to the end of the frame. The 16 bits sampled at those rising `mdc` edges land MSB first in bits [15:0] of the status register (index 4).
- R6: In the indicator register (index 5), bit 0 (busy) is 1 for the whole transaction. Bit 2 (not valid) is 1 from the start of a read until its last bit is taken. Both are 0 when the transaction is over.
- R7: `mdio_o` changes only at a falling edge of `mdc`, and `mdc` stays low whenever no transaction is running.
- R8: One `mdc` period lasts 4*(sel+1) system clocks, where sel is configuration bits [2:0].
- R9: While busy is 1, writes to the address, control-data and command registers are ignored, and the running frame is unchanged.
- R10: Setting configuration bit 31 aborts any running transaction within two clocks. It clears busy and not-valid and blocks new transactions until the bit is cleared again.
- R11: Command bit 1 is mirrored in indicator bit 1 (scan requested) and does not by itself start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the register indexed in the previous cycle |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions assume the host clears configuration bit 31 only while the engine is idle. They also assume that `reg_wr` is a clean single-cycle strobe and that `mdio_i` changes only while `mdc` is low. The bench drives registers at the falling system clock edge. Its PHY responder changes `mdio_i` only at falling `mdc` edges, so every sample taken at a rising edge sees a settled value. The random rounds keep the divide select small and always wait for busy to drop before starting the next transaction. Writes during busy and aborts happen only in the directed cases.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam logic [2:0] RG_CFG  = 3'd0;
  localparam logic [2:0] RG_CMD  = 3'd1;
  localparam logic [2:0] RG_ADDR = 3'd2;
  localparam logic [2:0] RG_CTRL = 3'd3;
  localparam logic [2:0] RG_STAT = 3'd4;
  localparam logic [2:0] RG_IND  = 3'd5;

  localparam int PHY_LSB  = 8;
  localparam int REGN_LSB = 0;
  localparam int FLD_W    = 5;
  localparam int DAT_W    = 16;

  typedef struct packed {
    logic             is_read;
    logic [FLD_W-1:0] phy;
    logic [FLD_W-1:0] regn;
    logic [DAT_W-1:0] wdata;
  } mdio_req_t;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int SEL_W = 3,
  parameter int SHIFT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  localparam int CNT_W = SEL_W + SHIFT + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             tick;

  assign half_m1 = ((CNT_W'(sel) + CNT_W'(1)) << SHIFT) - CNT_W'(1);
  assign tick    = run && (cnt == half_m1);
  assign rise    = tick && !mdc;
  assign fall    = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R8: the clock only toggles after a full half-period count
  a_r8_toggle_spacing: assert property (@(posedge clk) disable iff (rst)
    run && $past(run) && !$stable(mdc) |-> $past(cnt) != '0 || half_m1 == '0);
endmodule

// File: rtl/mdio_engine.sv
`timescale 1ns/1ps
module mdio_engine import mdio_pkg::*; #(
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  mdio_req_t        req,
  input  logic             rise,
  input  logic             fall,
  input  logic             mdio_i,
  output logic             busy,
  output logic             done,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [DAT_W-1:0] rd_data
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_IDX    = PRE_LEN + 14;
  localparam int DAT_IDX   = PRE_LEN + 16;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] frame;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     nidx;
  logic                 is_rd;
  logic [DAT_W-1:0]     sh;

  assign nidx = idx + IDX_W'(1);
  assign done = busy && fall && (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      idx     <= '0;
      frame   <= '0;
      is_rd   <= 1'b0;
      sh      <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        idx     <= '0;
        is_rd   <= req.is_read;
        sh      <= '0;
        frame   <= {{PRE_LEN{1'b1}}, 2'b01,
                    (req.is_read ? 2'b10 : 2'b01),
                    req.phy, req.regn,
                    (req.is_read ? 2'b00 : 2'b10),
                    (req.is_read ? {DAT_W{1'b0}} : req.wdata)};
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b1;
      end
    end else begin
      if (rise && is_rd && (int'(idx) >= DAT_IDX))
        sh <= {sh[DAT_W-2:0], mdio_i};
      if (fall) begin
        if (idx == LAST) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b0;
          mdio_oe <= 1'b0;
          if (is_rd) rd_data <= sh;
        end else begin
          idx     <= nidx;
          mdio_o  <= frame[LAST - nidx];
          mdio_oe <= !is_rd || (int'(nidx) < TA_IDX);
        end
      end
    end
  end

  // R5: the data line stays released through turnaround and data of a read
  a_r5_read_release: assert property (@(posedge clk) disable iff (rst)
    busy && is_rd && $past(busy) && (int'(idx) >= TA_IDX) |-> !mdio_oe);
  // R4: a write frame keeps driving the line for its whole length
  a_r4_write_drive: assert property (@(posedge clk) disable iff (rst)
    busy && !is_rd |-> mdio_oe);
endmodule

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
module mdio_regs import mdio_pkg::*; #(
  parameter int BUS_W = 32,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             busy,
  input  logic             done,
  input  logic [DAT_W-1:0] rd_data,
  output logic [BUS_W-1:0] rdata,
  output logic             start,
  output mdio_req_t        req,
  output logic             mgmt_rst,
  output logic [SEL_W-1:0] div_sel
);
  localparam int RST_BIT = BUS_W - 1;

  logic [1:0]       cmd_q;
  logic [FLD_W-1:0] phy_q;
  logic [FLD_W-1:0] regn_q;
  logic [DAT_W-1:0] ctrl_q;
  logic             nv_q;
  logic             start_rd;
  logic             start_wr;
  logic             open_wr;
  logic [BUS_W-1:0] rd_nxt;

  assign open_wr  = wr && !busy;
  assign start_rd = open_wr && !mgmt_rst && (addr == RG_CMD) && !cmd_q[0] && wdata[0];
  assign start_wr = open_wr && !mgmt_rst && (addr == RG_CTRL);
  assign start    = start_rd || start_wr;

  always_comb begin
    req.is_read = start_rd;
    req.phy     = phy_q;
    req.regn    = regn_q;
    req.wdata   = wdata[DAT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mgmt_rst <= 1'b0;
      div_sel  <= '0;
      cmd_q    <= '0;
      phy_q    <= '0;
      regn_q   <= '0;
      ctrl_q   <= '0;
    end else begin
      if (wr && addr == RG_CFG) begin
        mgmt_rst <= wdata[RST_BIT];
        div_sel  <= wdata[SEL_W-1:0];
      end
      if (open_wr && addr == RG_CMD)  cmd_q <= wdata[1:0];
      if (open_wr && addr == RG_ADDR) begin
        phy_q  <= wdata[PHY_LSB +: FLD_W];
        regn_q <= wdata[REGN_LSB +: FLD_W];
      end
      if (open_wr && addr == RG_CTRL) ctrl_q <= wdata[DAT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mgmt_rst) nv_q <= 1'b0;
    else if (start_rd)   nv_q <= 1'b1;
    else if (done)       nv_q <= 1'b0;
  end

  always_comb begin
    rd_nxt = '0;
    case (addr)
      RG_CFG: begin
        rd_nxt[RST_BIT]     = mgmt_rst;
        rd_nxt[SEL_W-1:0]   = div_sel;
      end
      RG_CMD:  rd_nxt[1:0] = cmd_q;
      RG_ADDR: begin
        rd_nxt[PHY_LSB +: FLD_W]  = phy_q;
        rd_nxt[REGN_LSB +: FLD_W] = regn_q;
      end
      RG_CTRL: rd_nxt[DAT_W-1:0] = ctrl_q;
      RG_STAT: rd_nxt[DAT_W-1:0] = rd_data;
      RG_IND:  rd_nxt[2:0] = {nv_q, cmd_q[1], busy};
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end

  // R6: not-valid is only ever raised inside a running transaction
  a_r6_nv_within_busy: assert property (@(posedge clk) disable iff (rst)
    nv_q |-> busy);
  // R9: address writes during busy leave the stored fields alone
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
    busy && wr && addr == RG_ADDR |=> $stable(phy_q) && $stable(regn_q));
  // R3: re-writing a set read bit never launches a transaction
  a_r3_no_relaunch: assert property (@(posedge clk) disable iff (rst)
    wr && addr == RG_CMD && cmd_q[0] && !busy |=> !$rose(busy));
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master import mdio_pkg::*; #(
  parameter int BUS_W   = 32,
  parameter int SEL_W   = 3,
  parameter int SHIFT   = 1,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic             start;
  mdio_req_t        req;
  logic             mgmt_rst;
  logic [SEL_W-1:0] div_sel;
  logic             busy;
  logic             done;
  logic [DAT_W-1:0] rd_data;
  logic             eng_rst;
  logic             rise;
  logic             fall;

  assign eng_rst = rst || mgmt_rst;

  mdio_regs #(.BUS_W(BUS_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .rdata(reg_rdata),
    .start(start), .req(req), .mgmt_rst(mgmt_rst), .div_sel(div_sel)
  );

  mdio_clkgen #(.SEL_W(SEL_W), .SHIFT(SHIFT)) u_clk (
    .clk(clk), .rst(eng_rst), .run(busy), .sel(div_sel),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_engine #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst(eng_rst), .start(start), .req(req), .rise(rise),
    .fall(fall), .mdio_i(mdio_i), .busy(busy), .done(done),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data)
  );

  // R7: the clock rests low outside a transaction
  a_r7_mdc_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
  // R7: data out only moves together with a falling clock
  a_r7_out_on_fall: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) && !$stable(mdio_o) |-> $fell(mdc));
  // R10: the management reset clears busy by the following cycle
  a_r10_abort: assert property (@(posedge clk) disable iff (rst)
    mgmt_rst |=> !busy);
  // R3 / R4: a transaction only begins after a command or control-data write
  a_r4_start_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wr) && ($past(reg_addr) == RG_CMD || $past(reg_addr) == RG_CTRL));
endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  mdio_master i_mdio_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #2.5 clk = ~clk;

  // PHY side: capture on rising mdc, reply on falling mdc
  logic [63:0] cap = '0;
  logic [63:0] cap_oe = '0;
  logic [15:0] resp = '0;
  int   bitcnt = 0;
  int   frames = 0;
  time  last_rise = 0;
  time  per = 0;

  always @(posedge mdc) begin
    cap    = {cap[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    bitcnt = bitcnt + 1;
    if (bitcnt == 2) per = $time - last_rise;
    last_rise = $time;
    if (bitcnt == 64) begin
      frames = frames + 1;
      bitcnt = 0;
    end
  end

  always @(negedge mdc) begin
    if (bitcnt >= 48) mdio_i = resp[63 - bitcnt];
    else              mdio_i = 1'b1;
  end

  function automatic logic [63:0] exp_frame(bit rd, logic [4:0] phy, logic [4:0] rn, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rn,
            (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rreg(3'd5, v);
      if (v[0] == 1'b0) return;
    end
    chk("R6 busy never dropped", 64'd1, 64'd0);
  endtask

  task automatic do_write(logic [4:0] phy, logic [4:0] rn, logic [15:0] d, int sel);
    logic [31:0] v;
    int f0;
    f0 = frames;
    wreg(3'd2, {19'h0, phy, 3'h0, rn});
    wreg(3'd3, {16'h0, d});
    rreg(3'd5, v);
    chk("R6 busy during write", 64'(v[2:0]), 64'(3'b001));
    wait_idle();
    chk("R4 write frame bits", cap, exp_frame(1'b0, phy, rn, d));
    chk("R4 write drives all bits", cap_oe, {64{1'b1}});
    chk("R4 one frame per write", 64'(frames - f0), 64'd1);
    chk("R8 mdc period", 64'(per), 64'(20 * (sel + 1)));
  endtask

  task automatic do_read(logic [4:0] phy, logic [4:0] rn, logic [15:0] d, int sel);
    logic [31:0] v;
    resp = d;
    wreg(3'd2, {19'h0, phy, 3'h0, rn});
    wreg(3'd1, 32'h0);
    wreg(3'd1, 32'h1);
    rreg(3'd5, v);
    chk("R6 busy and not-valid during read", 64'(v[2:0]), 64'(3'b101));
    wait_idle();
    rreg(3'd5, v);
    chk("R6 flags clear after read", 64'(v[2:0]), 64'd0);
    rreg(3'd4, v);
    chk("R5 read data in status", 64'(v), 64'(d));
    chk("R5 read header bits", 64'(cap[63:18]), 64'(exp_frame(1'b1, phy, rn, d) >> 18));
    chk("R5 line released from turnaround", cap_oe, {{46{1'b1}}, 18'h0});
    chk("R8 mdc period", 64'(per), 64'(20 * (sel + 1)));
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int f0;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk("R1 mdc low", 64'(mdc), 64'd0);
    chk("R1 oe low", 64'(mdio_oe), 64'd0);
    rreg(3'd5, v); chk("R1 indicators", 64'(v), 64'd0);
    rreg(3'd0, v); chk("R1 config", 64'(v), 64'd0);
    rreg(3'd4, v); chk("R1 status", 64'(v), 64'd0);

    // R2 field positions
    wreg(3'd2, 32'hFFFF_FFFF);
    rreg(3'd2, v); chk("R2 address fields", 64'(v), 64'h1F1F);

    // directed write and read at sel 0
    do_write(5'h11, 5'h0A, 16'hA5C3, 0);
    rreg(3'd3, v); chk("R4 control readback", 64'(v), 64'hA5C3);
    do_read(5'h1F, 5'h1F, 16'h8001, 0);

    // R3 bit already 1: no new read
    f0 = frames;
    wreg(3'd1, 32'h1);
    repeat (40) @(negedge clk);
    rreg(3'd5, v); chk("R3 no relaunch busy", 64'(v[0]), 64'd0);
    chk("R3 no relaunch frame", 64'(frames - f0), 64'd0);

    // R9 writes during busy ignored
    wreg(3'd2, {19'h0, 5'h03, 3'h0, 5'h04});
    f0 = frames;
    wreg(3'd3, 32'h1234);
    wreg(3'd2, {19'h0, 5'h1C, 3'h0, 5'h1B});
    wreg(3'd3, 32'hFFFF);
    wreg(3'd1, 32'h0);
    rreg(3'd2, v); chk("R9 address kept", 64'(v), 64'h0304);
    wait_idle();
    chk("R9 frame unchanged", cap, exp_frame(1'b0, 5'h03, 5'h04, 16'h1234));
    chk("R9 single frame", 64'(frames - f0), 64'd1);
    rreg(3'd3, v); chk("R9 control kept", 64'(v), 64'h1234);
    rreg(3'd1, v); chk("R9 command kept", 64'(v), 64'h1);

    // R11 scan flag
    f0 = frames;
    wreg(3'd1, 32'h3);
    repeat (20) @(negedge clk);
    rreg(3'd5, v); chk("R11 scan flag", 64'(v[2:0]), 64'(3'b010));
    chk("R11 no frame", 64'(frames - f0), 64'd0);
    wreg(3'd1, 32'h0);

    // R10 abort and block
    wreg(3'd3, 32'h0F0F);
    repeat (100) @(negedge clk);
    wreg(3'd0, 32'h8000_0000);
    repeat (2) @(negedge clk);
    rreg(3'd5, v); chk("R10 flags cleared", 64'(v), 64'd0);
    chk("R10 mdc low", 64'(mdc), 64'd0);
    chk("R10 oe low", 64'(mdio_oe), 64'd0);
    wreg(3'd1, 32'h1);
    rreg(3'd5, v); chk("R10 start blocked", 64'(v[0]), 64'd0);
    wreg(3'd1, 32'h0);
    wreg(3'd0, 32'h0);
    bitcnt = 0;
    do_read(5'h05, 5'h02, 16'h3C5A, 0);

    // random rounds
    for (int k = 0; k < 8; k++) begin
      int sel;
      logic [4:0] p, r;
      logic [15:0] d;
      sel = int'($urandom % 2);
      p = 5'($urandom); r = 5'($urandom); d = 16'($urandom);
      wreg(3'd0, 32'(sel));
      if ($urandom % 2 == 0) do_write(p, r, d, sel);
      else                   do_read(p, r, d, sel);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule